// File: doc/BRIEF.md
# Extended-capabilities parallel port host handshake engine

This block is the host end of a bidirectional byte link over a parallel cable. In the forward direction it takes bytes from a valid/ready stream. It places each byte on the data bus and runs a fully interlocked four-edge exchange: the host strobe goes low, the peripheral's Busy goes high, the strobe goes high, and Busy goes low. In the reverse direction the bus is released. The peripheral then drives nAck low with a byte, the host raises its acknowledge line (nAutoFd), the peripheral raises nAck, and the host latches the byte and drops its acknowledge. Each direction has its own idle state. A level request from the host logic chooses the direction. The turnaround always passes through a cycle with the bus undriven.

Every incoming cable line passes through a two-stage synchronizer. A programmable number of clocks sets the data setup time before the strobe falls. A programmable timeout guards every state that waits on the peripheral. An expired wait raises a one-cycle error pulse and returns the machine to the idle state of its current direction. A driver-mode select tells the pad ring whether the critical lines use push-pull or open-collector drive. It only switches while the handshake is idle, and it then holds off any new transfer for one clock. A low level on nFault during the forward phase is reported as a request from the peripheral to turn the channel around.

Top module: `ecp_host_link`

## Requirements
- R1: While reset is asserted and on the first cycle after it, nstrobe_o, nautofd_o and pd_oe are 1, and drv_push_pull, rx_valid, timeout_err and rev_request are 0.
- R2: A byte is accepted (tx_valid and tx_ready both 1 at a rising edge) only when all of these hold: the link is in forward idle, the synchronized Busy is low, dir_rev_req is 0 and no driver-mode change is pending. The accepted byte appears on pd_out at that edge.
- R3: nstrobe_o falls exactly setup_cycles+1 clocks after the accepted byte appears on pd_out. pd_out stays unchanged and pd_oe stays 1 for as long as nstrobe_o is low.
- R4: nstrobe_o returns high at the first edge that sees the synchronized Busy high. Forward idle is re-entered at the first edge after that which sees the synchronized Busy low.
- R5: rev_request is the synchronized inverse of nfault_i while the link is in a forward state (pd_oe high). It is 0 in every other state.
- R6: In reverse idle nautofd_o is 0. It rises at the edge that sees the synchronized nAck low. At the edge that then sees the synchronized nAck high, pd_in is copied to rx_data, rx_valid pulses for one clock and nautofd_o returns to 0.
- R7: Turning to reverse drops pd_oe one clock before reverse idle is entered. Turning back to forward passes through one clock with pd_oe still 0 before forward idle raises it. rx_valid is never 1 while pd_oe is 1.
- R8: In a state that waits on the peripheral (strobe low, strobe released, acknowledge high), a wait that lasts timeout_cycles+1 clocks ends with a one-cycle timeout_err pulse and a return to that direction's idle state.
- R9: drv_push_pull follows ecp_mode only while the link is in an idle state. After each change it is held for at least one further clock, and during that clock the handshake outputs do not move.
- R10: The state machine acts on a change of busy_i, nack_i or nfault_i at the second rising edge after the one that first samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | DATA_W | Byte to send to the peripheral |
| tx_valid | input | 1 | tx_data holds a byte |
| tx_ready | output | 1 | Byte accepted at this edge when tx_valid is 1 |
| rx_data | output | DATA_W | Last byte received from the peripheral |
| rx_valid | output | 1 | One-cycle pulse: rx_data is new |
| dir_rev_req | input | 1 | 1 requests the reverse direction, 0 the forward direction |
| ecp_mode | input | 1 | 1 requests push-pull drivers, 0 open-collector |
| setup_cycles | input | SETUP_W | Extra clocks of data setup before the strobe falls |
| timeout_cycles | input | TMO_W | Clocks allowed in a peripheral wait, less one |
| pd_out | output | DATA_W | Data bus value driven by the host |
| pd_in | input | DATA_W | Data bus value seen from the cable |
| pd_oe | output | 1 | Host drives the data bus |
| nstrobe_o | output | 1 | Host clock of the forward handshake |
| busy_i | input | 1 | Peripheral acknowledge of the forward handshake |
| nack_i | input | 1 | Peripheral clock of the reverse handshake |
| nautofd_o | output | 1 | Host acknowledge of the reverse handshake |
| nfault_i | input | 1 | Peripheral request for the reverse direction, active low |
| drv_push_pull | output | 1 | Driver mode for the critical lines: 1 push-pull |
| rev_request | output | 1 | Synchronized reverse request during the forward phase |
| timeout_err | output | 1 | One-cycle pulse when a peripheral wait expires |

## Verification
The assertions assume a peripheral that keeps to the interlock. Busy rises only after the strobe has fallen, and nAck is raised only while the host acknowledge is high. Under those conditions a strobe that rises while Busy was never seen high can only come from a timeout, and each received byte comes from a completed reverse exchange. The stimulus honours this by using a closed-loop peripheral that reacts only to the block's port outputs. Timeouts come from muting that peripheral in one direction, never from driving the lines out of order. The host-side inputs (tx stream, direction and mode requests, setup and timeout values) change only just after a rising edge.

// File: rtl/ecp_host_pkg.sv
package ecp_host_pkg;

  typedef enum logic [2:0] {
    ST_F_IDLE    = 3'd0,
    ST_F_SETUP   = 3'd1,
    ST_F_STROBE  = 3'd2,
    ST_F_RELEASE = 3'd3,
    ST_F_TURN    = 3'd4,
    ST_R_IDLE    = 3'd5,
    ST_R_ACK     = 3'd6,
    ST_R_TURN    = 3'd7
  } link_st_e;

  // Forward states: the host owns the data bus.
  function automatic logic is_fwd_phase(link_st_e s);
    return (s == ST_F_IDLE) || (s == ST_F_SETUP) ||
           (s == ST_F_STROBE) || (s == ST_F_RELEASE);
  endfunction

  // States where every handshake output sits at its resting level.
  function automatic logic is_idle_phase(link_st_e s);
    return (s == ST_F_IDLE) || (s == ST_R_IDLE);
  endfunction

  // States that wait for the peripheral and are guarded by the timer.
  function automatic logic is_wait_phase(link_st_e s);
    return (s == ST_F_STROBE) || (s == ST_F_RELEASE) || (s == ST_R_ACK);
  endfunction

  function automatic logic strobe_level(link_st_e s);
    return s != ST_F_STROBE;
  endfunction

  function automatic logic hostack_level(link_st_e s);
    return s != ST_R_IDLE;
  endfunction

endpackage

// File: rtl/ecp_sync2.sv
module ecp_sync2 #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

endmodule

// File: rtl/ecp_phase_cnt.sv
module ecp_phase_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         reached
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  function automatic logic [W-1:0] sat_inc(logic [W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!active || restart) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= sat_inc(cnt_q);
    end
  end

  assign reached = active && (cnt_q >= limit);

endmodule

// File: rtl/ecp_drive_mode.sv
module ecp_drive_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_req,
  input  logic may_switch,
  output logic drv_q,
  output logic hold
);

  logic settle_q;
  logic do_switch;

  assign do_switch = may_switch && !settle_q && (mode_req != drv_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_q    <= 1'b0;
      settle_q <= 1'b0;
    end else begin
      settle_q <= do_switch;
      if (do_switch) begin
        drv_q <= mode_req;
      end
    end
  end

  assign hold = (mode_req != drv_q) || settle_q;

endmodule

// File: rtl/ecp_host_link.sv
module ecp_host_link
  import ecp_host_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SETUP_W = 8,
  parameter int TMO_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              dir_rev_req,
  input  logic              ecp_mode,
  input  logic [SETUP_W-1:0] setup_cycles,
  input  logic [TMO_W-1:0]  timeout_cycles,
  output logic [DATA_W-1:0] pd_out,
  input  logic [DATA_W-1:0] pd_in,
  output logic              pd_oe,
  output logic              nstrobe_o,
  input  logic              busy_i,
  input  logic              nack_i,
  output logic              nautofd_o,
  input  logic              nfault_i,
  output logic              drv_push_pull,
  output logic              rev_request,
  output logic              timeout_err
);

  localparam int         N_SYNC   = 3;
  localparam logic [N_SYNC-1:0] SYNC_RST = 3'b011; // busy low, nAck high, nFault high

  link_st_e state_q, state_d;

  logic busy_s, nack_s, nfault_s;
  logic mode_hold;
  logic setup_done;
  logic tmo_hit;
  logic in_wait;
  logic state_moves;
  logic accept_tx;
  logic capture_rx;
  logic tmo_fire;

  // Cable inputs: two flops each
  ecp_sync2 #(.W(N_SYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({busy_i, nack_i, nfault_i}),
    .q     ({busy_s, nack_s, nfault_s})
  );

  assign in_wait     = is_wait_phase(state_q);
  assign state_moves = (state_d != state_q);

  ecp_phase_cnt #(.W(SETUP_W)) u_setup_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (state_q == ST_F_SETUP),
    .restart (state_moves),
    .limit   (setup_cycles),
    .reached (setup_done)
  );

  ecp_phase_cnt #(.W(TMO_W)) u_wait_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (in_wait),
    .restart (state_moves),
    .limit   (timeout_cycles),
    .reached (tmo_hit)
  );

  ecp_drive_mode u_drv_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_req   (ecp_mode),
    .may_switch (is_idle_phase(state_q)),
    .drv_q      (drv_push_pull),
    .hold       (mode_hold)
  );

  assign tx_ready = (state_q == ST_F_IDLE) && !mode_hold && !dir_rev_req && !busy_s;

  always_comb begin
    state_d    = state_q;
    accept_tx  = 1'b0;
    capture_rx = 1'b0;
    tmo_fire   = 1'b0;
    unique case (state_q)
      ST_F_IDLE: begin
        if (!mode_hold) begin
          if (dir_rev_req) begin
            state_d = ST_F_TURN;
          end else if (tx_valid && !busy_s) begin
            state_d   = ST_F_SETUP;
            accept_tx = 1'b1;
          end
        end
      end
      ST_F_SETUP: begin
        if (setup_done) state_d = ST_F_STROBE;
      end
      ST_F_STROBE: begin
        if (busy_s) begin
          state_d = ST_F_RELEASE;
        end else if (tmo_hit) begin
          state_d  = ST_F_IDLE;
          tmo_fire = 1'b1;
        end
      end
      ST_F_RELEASE: begin
        if (!busy_s) begin
          state_d = ST_F_IDLE;
        end else if (tmo_hit) begin
          state_d  = ST_F_IDLE;
          tmo_fire = 1'b1;
        end
      end
      ST_F_TURN: begin
        state_d = ST_R_IDLE;
      end
      ST_R_IDLE: begin
        if (!mode_hold) begin
          if (!dir_rev_req) begin
            state_d = ST_R_TURN;
          end else if (!nack_s) begin
            state_d = ST_R_ACK;
          end
        end
      end
      ST_R_ACK: begin
        if (nack_s) begin
          state_d    = ST_R_IDLE;
          capture_rx = 1'b1;
        end else if (tmo_hit) begin
          state_d  = ST_R_IDLE;
          tmo_fire = 1'b1;
        end
      end
      ST_R_TURN: begin
        state_d = ST_F_IDLE;
      end
      default: state_d = ST_F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_F_IDLE;
      nstrobe_o   <= 1'b1;
      nautofd_o   <= 1'b1;
      pd_oe       <= 1'b1;
      pd_out      <= '0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      state_q     <= state_d;
      nstrobe_o   <= strobe_level(state_d);
      nautofd_o   <= hostack_level(state_d);
      pd_oe       <= is_fwd_phase(state_d);
      rx_valid    <= capture_rx;
      timeout_err <= tmo_fire;
      if (accept_tx)  pd_out  <= tx_data;
      if (capture_rx) rx_data <= pd_in;
    end
  end

  assign rev_request = !nfault_s && is_fwd_phase(state_q);

endmodule

// File: rtl/ecp_host_link_chk.sv
module ecp_host_link_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nstrobe_o,
  input logic              nautofd_o,
  input logic              pd_oe,
  input logic [DATA_W-1:0] pd_out,
  input logic              rx_valid,
  input logic              timeout_err,
  input logic              drv_push_pull,
  input logic              rev_request,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              busy_s,
  input logic              in_wait
);

  // R3
  strobe_hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nstrobe_o |-> pd_oe && $stable(pd_out));

  // R4
  strobe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nstrobe_o) |-> $past(busy_s) || timeout_err);

  // R2
  accept_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> pd_oe && nstrobe_o);

  // R7
  rx_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !pd_oe);

  // R6
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6
  rx_hostack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !nautofd_o);

  // R5
  rev_req_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rev_request |-> pd_oe);

  // R8
  err_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> $past(in_wait));

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> !timeout_err);

  // R9
  mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv_push_pull) |-> nstrobe_o && $past(nstrobe_o) && $stable(pd_oe));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(drv_push_pull) |=> $stable(drv_push_pull) && $stable(nstrobe_o)
                                && $stable(nautofd_o) && $stable(pd_oe));

endmodule

bind ecp_host_link ecp_host_link_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .nstrobe_o     (nstrobe_o),
  .nautofd_o     (nautofd_o),
  .pd_oe         (pd_oe),
  .pd_out        (pd_out),
  .rx_valid      (rx_valid),
  .timeout_err   (timeout_err),
  .drv_push_pull (drv_push_pull),
  .rev_request   (rev_request),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .busy_s        (busy_s),
  .in_wait       (in_wait)
);

// File: tb/ecp_host_link_tb.sv
module ecp_host_link_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  // phase numbers of the reference model
  localparam int P_FI = 0, P_FS = 1, P_FST = 2, P_FR = 3, P_FT = 4, P_RI = 5, P_RA = 6, P_RT = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       dir_rev_req = 1'b0;
  logic       ecp_mode = 1'b0;
  logic [7:0] setup_cycles = '0;
  logic [11:0] timeout_cycles = 12'd20;
  logic [7:0] pd_out;
  logic [7:0] pd_in = '0;
  logic       pd_oe;
  logic       nstrobe_o;
  logic       busy_i = 1'b0;
  logic       nack_i = 1'b1;
  logic       nautofd_o;
  logic       nfault_i = 1'b1;
  logic       drv_push_pull;
  logic       rev_request;
  logic       timeout_err;

  ecp_host_link u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .dir_rev_req(dir_rev_req), .ecp_mode(ecp_mode),
    .setup_cycles(setup_cycles), .timeout_cycles(timeout_cycles),
    .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe),
    .nstrobe_o(nstrobe_o), .busy_i(busy_i), .nack_i(nack_i),
    .nautofd_o(nautofd_o), .nfault_i(nfault_i),
    .drv_push_pull(drv_push_pull), .rev_request(rev_request),
    .timeout_err(timeout_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int   mph = P_FI;
  int   m_scnt = 0, m_tcnt = 0;
  bit   m_drv = 0, m_settle = 0;
  bit   m_rxv = 0, m_err = 0;
  logic [7:0] m_pd = '0, m_rxd = '0;
  bit   q_busy[$], q_nack[$], q_nflt[$];
  bit   model_live = 0;

  function automatic bit m_fwd(int p);  return p <= P_FR; endfunction
  function automatic bit m_wait(int p); return p == P_FST || p == P_FR || p == P_RA; endfunction
  function automatic bit m_idle(int p); return p == P_FI || p == P_RI; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mph = P_FI; m_scnt = 0; m_tcnt = 0; m_drv = 0; m_settle = 0;
      m_rxv = 0; m_err = 0; m_pd = '0; m_rxd = '0;
      q_busy = '{0, 0}; q_nack = '{1, 1}; q_nflt = '{1, 1};
      model_live = 1;
    end else begin
      bit bs, ns, hold, sw;
      int nph;
      bs = q_busy.pop_front(); q_busy.push_back(busy_i);
      ns = q_nack.pop_front(); q_nack.push_back(nack_i);
      void'(q_nflt.pop_front()); q_nflt.push_back(nfault_i);
      hold = (ecp_mode != m_drv) || m_settle;
      nph = mph; m_rxv = 0; m_err = 0;
      case (mph)
        P_FI: if (!hold) begin
                if (dir_rev_req) nph = P_FT;
                else if (tx_valid && !bs) begin nph = P_FS; m_pd = tx_data; end
              end
        P_FS: if (m_scnt >= int'(setup_cycles)) nph = P_FST;
        P_FST: if (bs) nph = P_FR;
               else if (m_tcnt >= int'(timeout_cycles)) begin nph = P_FI; m_err = 1; end
        P_FR: if (!bs) nph = P_FI;
              else if (m_tcnt >= int'(timeout_cycles)) begin nph = P_FI; m_err = 1; end
        P_FT: nph = P_RI;
        P_RI: if (!hold) begin
                if (!dir_rev_req) nph = P_RT;
                else if (!ns) nph = P_RA;
              end
        P_RA: if (ns) begin nph = P_RI; m_rxd = pd_in; m_rxv = 1; end
              else if (m_tcnt >= int'(timeout_cycles)) begin nph = P_RI; m_err = 1; end
        default: nph = P_FI;
      endcase
      m_scnt = (mph == P_FS && nph == P_FS) ? m_scnt + 1 : 0;
      m_tcnt = (m_wait(mph) && nph == mph) ? m_tcnt + 1 : 0;
      sw = m_idle(mph) && !m_settle && (ecp_mode != m_drv);
      if (sw) m_drv = ecp_mode;
      m_settle = sw;
      mph = nph;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (model_live) begin
      bit e_ready, e_rev;
      e_ready = (mph == P_FI) && !((ecp_mode != m_drv) || m_settle) && !dir_rev_req && !q_busy[0];
      e_rev   = m_fwd(mph) && !q_nflt[0];
      check(nstrobe_o === (mph != P_FST), "R3", "nstrobe_o", nstrobe_o, mph != P_FST);
      check(nautofd_o === (mph != P_RI), "R6", "nautofd_o", nautofd_o, mph != P_RI);
      check(pd_oe === m_fwd(mph), "R7", "pd_oe", pd_oe, m_fwd(mph));
      check(pd_out === m_pd, "R2", "pd_out", pd_out, m_pd);
      check(tx_ready === e_ready, "R2", "tx_ready", tx_ready, e_ready);
      check(rx_valid === m_rxv, "R6", "rx_valid", rx_valid, m_rxv);
      check(rx_data === m_rxd, "R6", "rx_data", rx_data, m_rxd);
      check(timeout_err === m_err, "R8", "timeout_err", timeout_err, m_err);
      check(drv_push_pull === m_drv, "R9", "drv_push_pull", drv_push_pull, m_drv);
      check(rev_request === e_rev, "R5", "rev_request", rev_request, e_rev);
    end
  end

  // ---------------- peripheral responder ----------------
  bit   mute_fwd = 0, mute_rev = 0;
  logic [7:0] periph_got[$];
  logic [7:0] periph_send[$];
  logic [7:0] host_got[$];
  int   err_seen = 0;
  int   revreq_seen = 0;

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      busy_i = 1'b0; nack_i = 1'b1;
    end else begin
      if (!busy_i && !nstrobe_o && !mute_fwd) begin
        busy_i = 1'b1; periph_got.push_back(pd_out);
      end else if (busy_i && nstrobe_o) begin
        busy_i = 1'b0;
      end
      if (!pd_oe) begin
        if (nack_i && !nautofd_o && periph_send.size() > 0) begin
          pd_in = periph_send.pop_front(); nack_i = 1'b0;
        end else if (!nack_i && nautofd_o && !mute_rev) begin
          nack_i = 1'b1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) host_got.push_back(rx_data);
      if (timeout_err) err_seen++;
      if (rev_request) revreq_seen++;
    end
  end

  // R3: setup measured from the accepting edge to the falling strobe
  bit armed = 0;
  int meas = 0;
  int setup_checks = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (armed) begin
        meas++;
        if (!nstrobe_o) begin
          check(meas == int'(setup_cycles) + 2, "R3", "setup clocks", meas, int'(setup_cycles) + 2);
          setup_checks++;
          armed = 0;
        end
      end
      if (tx_valid && tx_ready) begin armed = 1; meas = 0; end
    end
  end

  // ---------------- host-side stimulus ----------------
  logic [7:0] exp_fwd[$];
  logic [7:0] exp_rev[$];
  bit done = 0;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit expect_arrive);
    tx_data = b; tx_valid = 1'b1;
    do @(negedge clk); while (!tx_ready);
    @(posedge clk); #1;
    tx_valid = 1'b0;
    if (expect_arrive) exp_fwd.push_back(b);
  endtask

  task automatic wait_err();
    int start;
    start = err_seen;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (err_seen != start) break;
    end
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(nstrobe_o === 1'b1 && nautofd_o === 1'b1 && pd_oe === 1'b1, "R1",
          "reset handshake lines", {nstrobe_o, nautofd_o, pd_oe}, 3'b111);
    check(drv_push_pull === 1'b0 && rx_valid === 1'b0 && timeout_err === 1'b0, "R1",
          "reset flags", {drv_push_pull, rx_valid, timeout_err}, 3'b000);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(nstrobe_o === 1'b1 && pd_oe === 1'b1 && rev_request === 1'b0, "R1",
          "first cycle after reset", {nstrobe_o, pd_oe, rev_request}, 3'b110);
    @(posedge clk); #1;

    // R9: mode switch in forward idle
    ecp_mode = 1'b1;
    tick(4);

    // R2 R3 R4: forward bytes with several setup lengths
    setup_cycles = 8'd0;
    send_byte(8'hA5, 1);
    send_byte(8'h3C, 1);
    setup_cycles = 8'd3;
    send_byte(8'hFF, 1);
    nfault_i = 1'b0;        // R5 request during forward traffic
    send_byte(8'h00, 1);
    setup_cycles = 8'd7;
    send_byte(8'h81, 1);
    tick(6);
    nfault_i = 1'b1;
    tick(12);

    // R8: forward timeout with a silent peripheral
    mute_fwd = 1;
    send_byte(8'h77, 0);
    wait_err();
    mute_fwd = 0;
    tick(10);

    // R7 R6: turn around and receive
    nfault_i = 1'b0;        // R5: must not be reported in reverse
    dir_rev_req = 1'b1;
    periph_send.push_back(8'h5A); exp_rev.push_back(8'h5A);
    periph_send.push_back(8'hC3); exp_rev.push_back(8'hC3);
    periph_send.push_back(8'h01); exp_rev.push_back(8'h01);
    for (int i = 0; i < 400 && host_got.size() < 3; i++) tick(1);
    nfault_i = 1'b1;

    // R9: mode switch in reverse idle
    ecp_mode = 1'b0;
    tick(6);

    // R8: reverse timeout, then the stalled byte completes
    mute_rev = 1;
    periph_send.push_back(8'h9E); exp_rev.push_back(8'h9E);
    wait_err();
    mute_rev = 0;
    for (int i = 0; i < 400 && host_got.size() < 4; i++) tick(1);
    tick(4);

    // R7: back to forward, one more byte
    dir_rev_req = 1'b0;
    ecp_mode = 1'b1;
    setup_cycles = 8'd1;
    send_byte(8'h42, 1);
    tick(30);

    // end-of-run checks
    check(periph_got.size() == exp_fwd.size(), "R2", "bytes at peripheral", periph_got.size(), exp_fwd.size());
    for (int i = 0; i < exp_fwd.size() && i < periph_got.size(); i++)
      check(periph_got[i] === exp_fwd[i], "R4", "forward byte", periph_got[i], exp_fwd[i]);
    check(host_got.size() == exp_rev.size(), "R6", "bytes at host", host_got.size(), exp_rev.size());
    for (int i = 0; i < exp_rev.size() && i < host_got.size(); i++)
      check(host_got[i] === exp_rev[i], "R6", "reverse byte", host_got[i], exp_rev[i]);
    check(err_seen >= 2, "R8", "timeout pulses", err_seen, 2);
    check(revreq_seen > 0, "R5", "reverse request seen", revreq_seen, 1);
    check(setup_checks >= 6, "R3", "setup measurements", setup_checks, 6);
    check(drv_push_pull === 1'b1, "R9", "final driver mode", drv_push_pull, 1'b1);
    // R10 is covered by the per-cycle model, which delays every cable input by two samples
    done = 1;
  end

  initial begin
    for (int i = 0; i < WATCHDOG && !done; i++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule